// File: doc/BRIEF.md
# Serial Register-Write Port with Frame-Length Detection

This block is a write-only, three-wire serial slave that loads a small bank of 16-bit configuration registers. A host raises chip select, clocks in a frame most-significant bit first on the rising edge of the serial clock, and then lowers chip select. The block counts the serial clock rising edges seen while chip select was high and only decides at the falling edge of chip select whether the frame is to be acted on. Two frame lengths are accepted: a 30-bit frame, and a 32-bit frame that carries two leading header bits in front of the same 30-bit body.

The 30-bit body holds, in transmission order, a direction bit that must be 0 for a write, an 8-bit device identifier that must match the configured value, a 5-bit register address, and 16 data bits (upper byte first). Seven addresses are mapped: 0 to 5 and 16. A frame that passes every check loads its data into the addressed register. All register contents are exposed as parallel outputs, and each accepted write is announced by a one-cycle strobe with the written address.

All three serial inputs are brought into the system clock domain through synchronizer chains, so the serial clock must run at no more than a quarter of the system clock rate.

Top module: `ser_regwrite_port`

## Requirements
- R1: While `rst` is high at a clock edge, every register output and `wr_stb_o` are 0 after that edge, and `wr_addr_o` is 0.
- R2: A 32-bit frame whose first two bits are 1,1, followed by direction bit 0, identifier `DEV_ID` (8'b10100100 by default, MSB first), a mapped 5-bit address and 16 data bits loads those data bits into the addressed register.
- R3: A 30-bit frame of direction bit 0, identifier `DEV_ID`, a mapped address and 16 data bits loads the addressed register in the same way.
- R4: A frame whose number of serial clock rising edges while chip select was high is anything other than 30 or 32 (including 33 or more, where the count saturates) changes no register and raises no strobe.
- R5: A 32-bit frame whose two leading bits are not both 1 changes no register and raises no strobe.
- R6: A frame whose direction bit is 1 changes no register and raises no strobe.
- R7: A frame whose identifier differs from `DEV_ID` in any bit changes no register and raises no strobe.
- R8: A frame that passes all other checks but carries an address other than 0..5 or 16 changes no register and raises no strobe.
- R9: Register index k (bits [16k+15:16k] of `regs_o`) holds address k for k = 0..5 and address 16 for k = 6; a write changes only that one register.
- R10: `wr_stb_o` is high for exactly one cycle per accepted write, with `wr_addr_o` holding the written address in that cycle.
- R11: Register contents change only in a cycle where `wr_stb_o` is high, and only after chip select has fallen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_i | input | 1 | Chip select, active high, asynchronous |
| sclk_i | input | 1 | Serial clock, asynchronous, at most clk/4 |
| sdi_i | input | 1 | Serial data, sampled on the serial clock rising edge |
| regs_o | output | 112 | All seven registers, register k at bits [16k+15:16k] |
| wr_stb_o | output | 1 | One-cycle pulse per accepted write |
| wr_addr_o | output | 5 | Address of the accepted write |

## Verification
The bench builds the block with its default parameters: identifier 8'b10100100, six low registers plus the one at address 16, and two synchronizer stages, with the serial clock at one eighth of the system clock. These values put every mapped address, both unmapped neighbours of the map (6 and 17), single-bit identifier faults, wrong headers, and frame lengths of 29, 31, 33 and 40 edges within reach of short frames, so the saturating counter and each rejection path are all exercised against a register model.

// File: rtl/srw_pkg.sv
package srw_pkg;
  localparam int DATA_W   = 16;
  localparam int ADDR_W   = 5;
  localparam int ID_W     = 8;
  localparam int HDR_W    = 2;
  localparam int SHORT_LEN = 1 + ID_W + ADDR_W + DATA_W;
  localparam int LONG_LEN  = SHORT_LEN + HDR_W;
  localparam int CNT_W     = $clog2(LONG_LEN + 2);
  // field positions within the received word (last bit received is bit 0)
  localparam int DATA_LSB = 0;
  localparam int ADDR_LSB = DATA_LSB + DATA_W;
  localparam int ID_LSB   = ADDR_LSB + ADDR_W;
  localparam int DIR_POS  = ID_LSB + ID_W;
  localparam int HDR_LSB  = DIR_POS + 1;
endpackage

// File: rtl/srw_sync.sv
module srw_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/srw_rx.sv
module srw_rx
  import srw_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                cs_s,
  input  logic                sclk_s,
  input  logic                sdi_s,
  output logic [LONG_LEN-1:0] frame_o,
  output logic [CNT_W-1:0]    len_o,
  output logic                done_o
);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(LONG_LEN + 1);

  logic cs_prev, sclk_prev;
  logic sclk_rise, cs_rise, cs_fall;

  assign sclk_rise = sclk_s & ~sclk_prev & cs_s;
  assign cs_rise   = cs_s & ~cs_prev;
  assign cs_fall   = ~cs_s & cs_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_prev   <= 1'b0;
      sclk_prev <= 1'b0;
      frame_o   <= '0;
      len_o     <= '0;
      done_o    <= 1'b0;
    end else begin
      cs_prev   <= cs_s;
      sclk_prev <= sclk_s;
      done_o    <= cs_fall;
      if (cs_rise) begin
        frame_o <= '0;
        len_o   <= '0;
      end else if (sclk_rise) begin
        frame_o <= {frame_o[LONG_LEN-2:0], sdi_s};
        if (len_o != CNT_SAT) len_o <= len_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/srw_decode.sv
module srw_decode
  import srw_pkg::*;
#(
  parameter logic [ID_W-1:0]   DEV_ID     = 8'b1010_0100,
  parameter int                LOW_REGS   = 6,
  parameter logic [ADDR_W-1:0] SETUP_ADDR = 5'b10000,
  localparam int               NUM_REGS   = LOW_REGS + 1,
  localparam int               IDX_W      = $clog2(NUM_REGS)
) (
  input  logic [LONG_LEN-1:0] frame_i,
  input  logic [CNT_W-1:0]    len_i,
  input  logic                done_i,
  output logic                wr_en_o,
  output logic [IDX_W-1:0]    wr_idx_o,
  output logic [ADDR_W-1:0]   wr_addr_o,
  output logic [DATA_W-1:0]   wr_data_o
);
  logic is_short, is_long, hdr_ok, dir_ok, id_ok, low_hit, setup_hit;

  assign is_short  = (len_i == CNT_W'(SHORT_LEN));
  assign is_long   = (len_i == CNT_W'(LONG_LEN));
  assign hdr_ok    = !is_long || (frame_i[HDR_LSB +: HDR_W] == {HDR_W{1'b1}});
  assign dir_ok    = (frame_i[DIR_POS] == 1'b0);
  assign id_ok     = (frame_i[ID_LSB +: ID_W] == DEV_ID);
  assign wr_addr_o = frame_i[ADDR_LSB +: ADDR_W];
  assign wr_data_o = frame_i[DATA_LSB +: DATA_W];
  assign low_hit   = (int'(wr_addr_o) < LOW_REGS);
  assign setup_hit = (wr_addr_o == SETUP_ADDR);

  always_comb begin
    wr_idx_o = low_hit ? IDX_W'(wr_addr_o) : IDX_W'(LOW_REGS);
    wr_en_o  = done_i && (is_short || is_long) && hdr_ok && dir_ok && id_ok
               && (low_hit || setup_hit);
  end
endmodule

// File: rtl/ser_regwrite_port.sv
module ser_regwrite_port
  import srw_pkg::*;
#(
  parameter logic [ID_W-1:0]   DEV_ID      = 8'b1010_0100,
  parameter int                LOW_REGS    = 6,
  parameter logic [ADDR_W-1:0] SETUP_ADDR  = 5'b10000,
  parameter int                SYNC_STAGES = 2,
  localparam int               NUM_REGS    = LOW_REGS + 1,
  localparam int               IDX_W       = $clog2(NUM_REGS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cs_i,
  input  logic                       sclk_i,
  input  logic                       sdi_i,
  output logic [NUM_REGS*DATA_W-1:0] regs_o,
  output logic                       wr_stb_o,
  output logic [ADDR_W-1:0]          wr_addr_o
);
  logic                cs_s, sclk_s, sdi_s;
  logic [LONG_LEN-1:0] rx_frame;
  logic [CNT_W-1:0]    rx_len;
  logic                rx_done;
  logic                wr_en;
  logic [IDX_W-1:0]    wr_idx;
  logic [ADDR_W-1:0]   dec_addr;
  logic [DATA_W-1:0]   wr_data;

  srw_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({cs_i, sclk_i, sdi_i}),
    .q_o ({cs_s, sclk_s, sdi_s})
  );

  srw_rx u_rx (
    .clk     (clk),
    .rst     (rst),
    .cs_s    (cs_s),
    .sclk_s  (sclk_s),
    .sdi_s   (sdi_s),
    .frame_o (rx_frame),
    .len_o   (rx_len),
    .done_o  (rx_done)
  );

  srw_decode #(.DEV_ID(DEV_ID), .LOW_REGS(LOW_REGS), .SETUP_ADDR(SETUP_ADDR)) u_dec (
    .frame_i   (rx_frame),
    .len_i     (rx_len),
    .done_i    (rx_done),
    .wr_en_o   (wr_en),
    .wr_idx_o  (wr_idx),
    .wr_addr_o (dec_addr),
    .wr_data_o (wr_data)
  );

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)                                   q <= '0;
      else if (wr_en && wr_idx == IDX_W'(g))     q <= wr_data;
    end
    assign regs_o[g*DATA_W +: DATA_W] = q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_stb_o  <= 1'b0;
      wr_addr_o <= '0;
    end else begin
      wr_stb_o  <= wr_en;
      if (wr_en) wr_addr_o <= dec_addr;
    end
  end
endmodule

// File: rtl/srw_checker.sv
module srw_checker
  import srw_pkg::*;
#(
  parameter int                LOW_REGS   = 6,
  parameter logic [ADDR_W-1:0] SETUP_ADDR = 5'b10000,
  localparam int               NUM_REGS   = LOW_REGS + 1
) (
  input logic                       clk,
  input logic                       rst,
  input logic [NUM_REGS*DATA_W-1:0] regs,
  input logic                       wr_stb,
  input logic [ADDR_W-1:0]          wr_addr,
  input logic [CNT_W-1:0]           len
);
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (wr_stb == 1'b0 && regs == '0));

  a_r10_strobe_single: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> !wr_stb);

  a_r11_change_only_on_strobe: assert property (@(posedge clk) disable iff (rst)
    !wr_stb |-> $stable(regs));

  a_r4_strobe_needs_valid_len: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> (len == CNT_W'(SHORT_LEN) || len == CNT_W'(LONG_LEN)));

  a_r8_strobe_mapped_addr: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> (int'(wr_addr) < LOW_REGS || wr_addr == SETUP_ADDR));
endmodule

bind ser_regwrite_port srw_checker #(.LOW_REGS(LOW_REGS), .SETUP_ADDR(SETUP_ADDR)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .regs    (regs_o),
  .wr_stb  (wr_stb_o),
  .wr_addr (wr_addr_o),
  .len     (rx_len)
);

// File: tb/tb_ser_regwrite_port.sv
module tb_ser_regwrite_port;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_SCLK  = 4;
  localparam int NREG = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs = 1'b0, sclk = 1'b0, sdi = 1'b0;
  logic [NREG*16-1:0] regs;
  logic       wr_stb;
  logic [4:0] wr_addr;

  int total = 0;
  int bad = 0;
  logic [15:0] model [NREG];
  logic [20:0] expq [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ser_regwrite_port dut (
    .clk(clk), .rst(rst), .cs_i(cs), .sclk_i(sclk), .sdi_i(sdi),
    .regs_o(regs), .wr_stb_o(wr_stb), .wr_addr_o(wr_addr)
  );

  function automatic int idx_of(input logic [4:0] a);
    return (a < 5'd6) ? int'(a) : 6;
  endfunction

  function automatic logic [29:0] body(input logic dir, input logic [7:0] id,
                                       input logic [4:0] a, input logic [15:0] d);
    return {dir, id, a, d};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input int nbits, input logic [39:0] w);
    cs = 1'b1;
    repeat (HALF_SCLK) @(posedge clk);
    for (int i = nbits - 1; i >= 0; i--) begin
      sdi = w[i];
      repeat (HALF_SCLK) @(posedge clk);
      sclk = 1'b1;
      repeat (HALF_SCLK) @(posedge clk);
      sclk = 1'b0;
    end
    repeat (HALF_SCLK) @(posedge clk);
    cs = 1'b0;
    repeat (12) @(posedge clk);
  endtask

  // accepted write: push expectation, update model
  task automatic good(input string req, input int nbits, input logic [39:0] w,
                      input logic [4:0] a, input logic [15:0] d);
    expq.push_back({a, d});
    model[idx_of(a)] = d;
    send(nbits, w);
    compare_all(req);
  endtask

  task automatic ignored(input string req, input int nbits, input logic [39:0] w);
    send(nbits, w);
    compare_all(req);
  endtask

  task automatic compare_all(input string req);
    @(negedge clk);
    for (int k = 0; k < NREG; k++)
      check(req, {16'h0, regs[k*16 +: 16]}, {16'h0, model[k]});
  endtask

  // monitor: pops the scoreboard on every strobe
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && wr_stb) begin
        if (expq.size() == 0) begin
          check("R10 unexpected strobe", 32'd1, 32'd0);
        end else begin
          logic [20:0] e;
          e = expq.pop_front();
          check("R10 strobe addr", {27'h0, wr_addr}, {27'h0, e[20:16]});
          check("R9 addressed reg", {16'h0, regs[idx_of(e[20:16])*16 +: 16]}, {16'h0, e[15:0]});
          @(negedge clk);
          check("R10 strobe width", {31'h0, wr_stb}, 32'd0);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  localparam logic [7:0] ID = 8'b1010_0100;

  initial begin
    for (int k = 0; k < NREG; k++) model[k] = 16'h0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check("R1 regs reset", {31'h0, regs == '0}, 32'd1);
    check("R1 strobe reset", {31'h0, wr_stb}, 32'd0);
    check("R1 addr reset", {27'h0, wr_addr}, 32'd0);
    rst = 1'b0;
    repeat (3) @(posedge clk);

    // R2: 32-bit frames
    good("R2 long a0", 32, {8'h0, 2'b11, body(1'b0, ID, 5'd0, 16'hA55A)}, 5'd0, 16'hA55A);
    good("R2 long a3", 32, {8'h0, 2'b11, body(1'b0, ID, 5'd3, 16'h1234)}, 5'd3, 16'h1234);
    // R3: 30-bit frames
    good("R3 short a1", 30, {10'h0, body(1'b0, ID, 5'd1, 16'hBEEF)}, 5'd1, 16'hBEEF);
    good("R3 short a5", 30, {10'h0, body(1'b0, ID, 5'd5, 16'hFFFF)}, 5'd5, 16'hFFFF);
    // R9: address 16 -> register 6, and remaining low addresses
    good("R9 setup a16", 32, {8'h0, 2'b11, body(1'b0, ID, 5'd16, 16'h0F0F)}, 5'd16, 16'h0F0F);
    good("R9 a2", 30, {10'h0, body(1'b0, ID, 5'd2, 16'h8001)}, 5'd2, 16'h8001);
    good("R9 a4", 30, {10'h0, body(1'b0, ID, 5'd4, 16'h7E7E)}, 5'd4, 16'h7E7E);
    good("R3 overwrite a0", 30, {10'h0, body(1'b0, ID, 5'd0, 16'h0001)}, 5'd0, 16'h0001);

    // R4: wrong lengths
    ignored("R4 len29", 29, {11'h0, body(1'b0, ID, 5'd1, 16'h1111)} >> 1);
    ignored("R4 len31", 31, {9'h0, 1'b1, body(1'b0, ID, 5'd1, 16'h2222)});
    ignored("R4 len33", 33, {7'h0, 3'b111, body(1'b0, ID, 5'd1, 16'h3333)});
    ignored("R4 len40", 40, {8'hFF, 2'b11, body(1'b0, ID, 5'd1, 16'h4444)});
    // R5: bad header
    ignored("R5 hdr10", 32, {8'h0, 2'b10, body(1'b0, ID, 5'd2, 16'h5555)});
    ignored("R5 hdr01", 32, {8'h0, 2'b01, body(1'b0, ID, 5'd2, 16'h5556)});
    // R6: read direction
    ignored("R6 dir long", 32, {8'h0, 2'b11, body(1'b1, ID, 5'd3, 16'h6666)});
    ignored("R6 dir short", 30, {10'h0, body(1'b1, ID, 5'd3, 16'h6667)});
    // R7: identifier faults
    ignored("R7 id msb", 30, {10'h0, body(1'b0, ID ^ 8'h80, 5'd4, 16'h7777)});
    ignored("R7 id lsb", 32, {8'h0, 2'b11, body(1'b0, ID ^ 8'h01, 5'd4, 16'h7778)});
    // R8: unmapped addresses
    ignored("R8 a6", 30, {10'h0, body(1'b0, ID, 5'd6, 16'h8888)});
    ignored("R8 a17", 32, {8'h0, 2'b11, body(1'b0, ID, 5'd17, 16'h8889)});
    ignored("R8 a31", 30, {10'h0, body(1'b0, ID, 5'd31, 16'h888A)});

    // R11: a valid frame after rejected ones still writes
    good("R11 after rejects", 32, {8'h0, 2'b11, body(1'b0, ID, 5'd16, 16'hC3C3)}, 5'd16, 16'hC3C3);

    repeat (20) @(posedge clk);
    check("R10 all strobes seen", expq.size(), 32'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule